// File: doc/BRIEF.md
# DMA Mapping Permission Checker

This block decides whether an inbound DMA request may use the translation entry it has already hit. The request arrives with its direction (device reads memory or device writes memory), the 16-bit requester ID of the issuing device, and the 64-bit attribute word of the entry. One clock later the block returns an allow or deny verdict, a two-bit fault cause and a relaxed-ordering hint. Address translation, table lookup and fault logging are done by other blocks.

The check has two parts. The first is a direction grant: bit 0 of the attribute word lets the device read memory and bit 1 lets the device write memory. The second is an ownership check: bits 31:16 name the only requester allowed to use the mapping. When that field is all zero, the ownership check is switched off. Bits 5:4 set how many of the upper function-number bits are left out of the compare, so that a device using phantom functions can still match.

Top module: `dma_perm_check`

## Requirements
- R1: After synchronous active-high reset, `vld_o` is 0. `vld_o` is 1 exactly one clock after each cycle in which `vld_i` is 1, and 0 otherwise.
- R2: For a read request (`dir_i`=0), attribute bit 0 must be set. For a write request (`dir_i`=1), attribute bit 1 must be set. If the needed bit is clear, the request is denied with cause 2'b01.
- R3: When attribute bits 31:16 are all zero, the requester ID is not checked and any requester passes.
- R4: When attribute bits 31:16 are nonzero, they are compared with `rid_i`, laid out as bus[15:8], device[7:3], function[2:0]. A mismatch denies the request with cause 2'b10.
- R5: Attribute bits 5:4 (value p) leave the p most significant function bits (bits 2 down to 3-p) out of the compare. p = 3 leaves out all three function bits. Bus and device bits are always compared.
- R6: When both the direction check and the ownership check fail, the cause is 2'b01.
- R7: `allow_o` is 1 exactly when the cause is 2'b00.
- R8: `ro_hint_o` equals attribute bit 2 of the request and never changes the verdict.
- R9: Attribute bits 3, 15:6 and 63:32 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Request strobe |
| dir_i | input | 1 | 0 = device reads memory, 1 = device writes memory |
| rid_i | input | 16 | Requester ID {bus, device, function} |
| attr_i | input | 64 | Attribute word of the translation entry |
| vld_o | output | 1 | Verdict valid, one cycle after `vld_i` |
| allow_o | output | 1 | 1 = request permitted |
| cause_o | output | 2 | 00 allowed, 01 direction fault, 10 requester mismatch |
| ro_hint_o | output | 1 | Relaxed-ordering hint |

## Verification
The in-RTL assertions check the following on every cycle:
- the one-cycle strobe relation;
- that allow matches a zero cause;
- that the cause is never 2'b11;
- that the registered hint and cause follow the previous cycle's inputs and the internal fault wires;
- that a zero ownership field never produces a mismatch fault.

Only the scoreboard scenarios can show the following:
- that each phantom setting leaves out the right function bits;
- that reserved bits cannot change a result;
- that fault priority holds for real attribute and requester combinations.

// File: rtl/dma_perm_pkg.sv
package dma_perm_pkg;
  localparam int ATTR_W = 64;
  localparam int RID_W  = 16;
  localparam int FN_W   = 3;

  localparam int RD_BIT = 0;
  localparam int WR_BIT = 1;
  localparam int RO_BIT = 2;
  localparam int PH_LO  = 4;
  localparam int OWN_LO = 16;

  typedef enum logic [1:0] {
    CAUSE_OK   = 2'b00,
    CAUSE_DIR  = 2'b01,
    CAUSE_RID  = 2'b10,
    CAUSE_RSVD = 2'b11
  } cause_e;

  // Mask of requester-ID bits that take part in the compare for phantom setting p.
  function automatic logic [RID_W-1:0] rid_mask(input logic [1:0] p);
    logic [RID_W-1:0] m;
    m = '1;
    for (int b = 0; b < FN_W; b++) begin
      if (b >= FN_W - int'(p)) m[b] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/dma_dir_gate.sv
module dma_dir_gate
  import dma_perm_pkg::*;
(
  input  logic dir,
  input  logic rd_ok,
  input  logic wr_ok,
  output logic dir_fault
);
  always_comb dir_fault = dir ? ~wr_ok : ~rd_ok;
endmodule

// File: rtl/dma_rid_match.sv
module dma_rid_match
  import dma_perm_pkg::*;
#(
  parameter int W = RID_W
) (
  input  logic [W-1:0] rid,
  input  logic [W-1:0] owner,
  input  logic [1:0]   phantom,
  output logic         rid_fault
);
  logic [W-1:0] mask;
  logic         prot_on;

  always_comb begin
    mask      = rid_mask(phantom);
    prot_on   = |owner;
    rid_fault = prot_on && (((rid ^ owner) & mask) != '0);
  end

  // R3: a zero ownership field never produces a mismatch fault
  always_comb begin
    assert_no_rid_when_off_R3: assert (prot_on || !rid_fault);
  end
endmodule

// File: rtl/dma_perm_check.sv
module dma_perm_check
  import dma_perm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        vld_i,
  input  logic        dir_i,
  input  logic [15:0] rid_i,
  input  logic [63:0] attr_i,
  output logic        vld_o,
  output logic        allow_o,
  output logic [1:0]  cause_o,
  output logic        ro_hint_o
);
  logic       dir_fault_w;
  logic       rid_fault_w;
  logic [1:0] cause_w;

  dma_dir_gate u_dir (
    .dir      (dir_i),
    .rd_ok    (attr_i[RD_BIT]),
    .wr_ok    (attr_i[WR_BIT]),
    .dir_fault(dir_fault_w)
  );

  dma_rid_match #(.W(RID_W)) u_rid (
    .rid      (rid_i),
    .owner    (attr_i[OWN_LO +: RID_W]),
    .phantom  (attr_i[PH_LO +: 2]),
    .rid_fault(rid_fault_w)
  );

  // The direction fault has priority over the requester mismatch.
  always_comb begin
    if (dir_fault_w)      cause_w = CAUSE_DIR;
    else if (rid_fault_w) cause_w = CAUSE_RID;
    else                  cause_w = CAUSE_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o     <= 1'b0;
      allow_o   <= 1'b0;
      cause_o   <= CAUSE_OK;
      ro_hint_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        allow_o   <= (cause_w == CAUSE_OK);
        cause_o   <= cause_w;
        ro_hint_o <= attr_i[RO_BIT];
      end
    end
  end

  assert_vld_delay_R1: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o);
  assert_vld_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o);
  assert_allow_cause_R7: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (allow_o == (cause_o == CAUSE_OK)));
  assert_cause_legal_R6: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (cause_o != CAUSE_RSVD));
  assert_dir_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (vld_i && dir_fault_w) |=> (cause_o == CAUSE_DIR));
  assert_hint_R8: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> (ro_hint_o == $past(attr_i[RO_BIT])));
endmodule

// File: tb/dma_perm_check_tb_top.sv
module dma_perm_check_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst;
  logic        vld_i, dir_i;
  logic [15:0] rid_i;
  logic [63:0] attr_i;
  logic        vld_o, allow_o, ro_hint_o;
  logic [1:0]  cause_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct packed {
    logic       allow;
    logic [1:0] cause;
    logic       ro;
  } exp_t;

  exp_t        expq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_perm_check dut_i (
    .clk(clk), .rst(rst), .vld_i(vld_i), .dir_i(dir_i), .rid_i(rid_i),
    .attr_i(attr_i), .vld_o(vld_o), .allow_o(allow_o), .cause_o(cause_o),
    .ro_hint_o(ro_hint_o)
  );

  // Independent model. Function bits at or above position (3 - p) are ignored.
  function automatic exp_t model(logic dir, logic [15:0] rid, logic [63:0] a);
    exp_t e;
    logic dirbad, ridbad;
    int   keep;
    logic [15:0] own;
    own    = a[31:16];
    dirbad = dir ? !a[1] : !a[0];
    keep   = 3 - int'(a[5:4]);
    ridbad = 0;
    if (own != 0) begin
      if (rid[15:3] != own[15:3]) ridbad = 1;
      for (int i = 0; i < keep; i++) if (rid[i] != own[i]) ridbad = 1;
    end
    e.cause = dirbad ? 2'b01 : (ridbad ? 2'b10 : 2'b00);
    e.allow = (e.cause == 2'b00);
    e.ro    = a[2];
    return e;
  endfunction

  task automatic send(string tag, logic dir, logic [15:0] rid, logic [63:0] a);
    @(negedge clk);
    vld_i  = 1;
    dir_i  = dir;
    rid_i  = rid;
    attr_i = a;
    expq.push_back(model(dir, rid, a));
    tagq.push_back(tag);
    @(negedge clk);
    vld_i = 0;
  endtask

  // Monitor: compares each result with the next expected item.
  always @(negedge clk) begin
    if (!rst && vld_o) begin
      if (expq.size() == 0) begin
        errors++;
        checks++;
        $display("FAIL R1 unexpected vld_o actual=1 expected=0");
      end else begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        checks++;
        if ({allow_o, cause_o, ro_hint_o} !== e) begin
          errors++;
          $display("FAIL %s actual allow=%b cause=%b ro=%b expected allow=%b cause=%b ro=%b",
                   t, allow_o, cause_o, ro_hint_o, e.allow, e.cause, e.ro);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] own_a;

    rst    = 1;
    vld_i  = 0;
    dir_i  = 0;
    rid_i  = 0;
    attr_i = 0;
    repeat (3) @(negedge clk);

    checks++;
    if (vld_o !== 0) begin
      errors++;
      $display("FAIL R1 reset vld_o actual=%b expected=0", vld_o);
    end
    rst = 0;

    // R2: direction grant
    send("R2 read granted",     0, 16'h1234, 64'h1);
    send("R2 read denied",      0, 16'h1234, 64'h2);
    send("R2 write granted",    1, 16'h1234, 64'h2);
    send("R2 write denied",     1, 16'h1234, 64'h1);

    // R3: ownership check off when the owner field is zero
    send("R3 any rid passes",   1, 16'hFFFF, 64'h3);

    // R4: owner compare
    own_a = {32'h0, 16'hAB38, 16'h0003};
    send("R4 exact match",      0, 16'hAB38, own_a);
    send("R4 bus mismatch",     0, 16'hAC38, own_a);
    send("R4 func mismatch",    0, 16'hAB39, own_a);

    // R5: phantom setting, owner function 000
    send("R5 p1 ignores bit2",  0, 16'hAB3C, own_a | 64'h10);
    send("R5 p1 checks bit1",   0, 16'hAB3A, own_a | 64'h10);
    send("R5 p2 ignores bit1",  0, 16'hAB3E, own_a | 64'h20);
    send("R5 p2 checks bit0",   0, 16'hAB3D, own_a | 64'h20);
    send("R5 p3 ignores all",   0, 16'hAB3F, own_a | 64'h30);
    send("R5 p3 device bits",   0, 16'hAB40, own_a | 64'h30);

    // R6: both checks fail, direction fault wins
    send("R6 priority",         1, 16'h0000, {32'h0, 16'hAB38, 16'h0001});

    // R7: allow follows cause (checked in every compare above)
    send("R7 allowed write",    1, 16'hAB38, own_a);

    // R8: hint passes through without changing the verdict
    send("R8 hint on allowed",  0, 16'h0, 64'h5);
    send("R8 hint on denied",   1, 16'h0, 64'h5);

    // R9: reserved bits have no effect
    send("R9 reserved set allow", 0, 16'hAB38, own_a | 64'hFFFF_FFFF_0000_FFC8);
    send("R9 reserved set deny",  0, 16'hAB30, own_a | 64'hFFFF_FFFF_0000_FFC8 & ~64'h1);

    // R1: back-to-back requests
    @(negedge clk);
    vld_i = 1; dir_i = 0; rid_i = 16'h0; attr_i = 64'h1;
    expq.push_back(model(0, 16'h0, 64'h1)); tagq.push_back("R1 b2b first");
    @(negedge clk);
    attr_i = 64'h0;
    expq.push_back(model(0, 16'h0, 64'h0)); tagq.push_back("R1 b2b second");
    @(negedge clk);
    vld_i = 0;

    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results actual=%0d expected=0", expq.size());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule